// File: doc/BRIEF.md
# Pipelined Wormhole Packet Switch

This block forwards multi-flit packets between `NP` input ports and `NP` output ports. Every port moves one flit per cycle under a valid/ready handshake. A packet opens with a head flit, or is a single flit that is both head and tail. The head flit's destination field indexes a forwarding table, and the table entry names the output port. That output is then held for the packet until its closing flit has crossed.

Each flit passes through five stages in a fixed order: input buffer, route lookup, switch arbitration, crossbar traversal, output buffer. Only the opening flit performs the lookup and the arbitration. The flits that follow it use the crossbar path the opening flit reserved, so they pass only through buffering and traversal. Each output has a round-robin arbiter, and the arbiter's priority pointer moves past the winner once per packet. The table is loaded through a single-entry write port.

Top module: `wr_router`

## Requirements
- R1: While reset is held, and right after it, every `out_valid` bit is low and every `in_ready` bit is high.
- R2: The flit kind sits in bits [FLIT_W-1:FLIT_W-2]: 2'b01 opens a packet, 2'b00 continues it, 2'b10 closes it, and 2'b11 is a one-flit packet. An opening flit's bits [DEST_W-1:0] index the forwarding table. The packet leaves on the output port stored in that entry.
- R3: Each packet leaves one output with its flits in their original order. No flit of another packet appears on that output between the packet's opening flit and its closing flit.
- R4: A flit whose kind does not open a packet, reaching an input that has no packet in progress, is discarded and never appears on any output.
- R5: When several inputs contend for one output, each of them is served one packet before any of them is served a second one.
- R6: A lone one-flit packet on an idle switch, with its output ready, first shows `out_valid` after the fourth rising edge that follows the edge on which it was accepted.
- R7: While `out_valid` is high and `out_ready` is low, that output keeps `out_valid` high and its flit unchanged on the next cycle.
- R8: When a blocked output leaves an input's buffer full, that input drops `in_ready`, and every accepted flit is delivered once the output drains.
- R9: Writing the table with `tbl_we` replaces the entry at `tbl_dest` with `tbl_port`. After reset, entry d holds d modulo NP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NP | Per-input flit valid |
| in_ready | output | NP | Per-input buffer has room |
| in_flit | input | NP*FLIT_W | Input flits, port i in slice i |
| out_valid | output | NP | Per-output flit valid |
| out_ready | input | NP | Per-output downstream accept |
| out_flit | output | NP*FLIT_W | Output flits, port o in slice o |
| tbl_we | input | 1 | Forwarding table write strobe |
| tbl_dest | input | DEST_W | Table entry to write |
| tbl_port | input | log2(NP) | Output port stored in that entry |

## Verification
The switch is first tried with a lone one-flit packet, which pins down the pipeline depth. A rewritten table entry then shows that the lookup reads the live table and not the reset contents. A stray continuation flit on an idle input shows that it is discarded. All four inputs then send two packets each to the same output, which separates correct locking and round-robin order from interleaving or starvation. A long packet against a stalled output exercises buffer-full backpressure. Random packet lengths and destinations with a randomly stalling downstream exercise every lock and release path against the reference model.

// File: rtl/wr_pkg.sv
package wr_pkg;

   // Flit kind field: bit 0 marks an opening flit, bit 1 a closing flit
   typedef enum logic [1:0] {
      FK_BODY = 2'b00,
      FK_HEAD = 2'b01,
      FK_TAIL = 2'b10,
      FK_ONLY = 2'b11
   } flit_kind_e;

   typedef enum logic [1:0] {
      IN_IDLE    = 2'b00,
      IN_ROUTED  = 2'b01,
      IN_GRANTED = 2'b10
   } in_state_e;

   function automatic logic kind_opens(input logic [1:0] k);
      return k[0];
   endfunction

   function automatic logic kind_closes(input logic [1:0] k);
      return k[1];
   endfunction

endpackage

// File: rtl/wr_fifo.sv
module wr_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_valid,
   output logic         push_ready,
   input  logic [W-1:0] push_data,
   output logic         pop_valid,
   input  logic         pop_ready,
   output logic [W-1:0] pop_data
);

   if (DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wr_fifo: DEPTH must be a power of two");
   end

   if (DEPTH == 1) begin : g_single
      logic         full_q;
      logic [W-1:0] hold_q;

      assign push_ready = !full_q || pop_ready;
      assign pop_valid  = full_q;
      assign pop_data   = hold_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            full_q <= 1'b0;
            hold_q <= '0;
         end else begin
            if (push_valid && push_ready) begin
               full_q <= 1'b1;
               hold_q <= push_data;
            end else if (pop_ready) begin
               full_q <= 1'b0;
            end
         end
      end
   end else begin : g_ring
      localparam int AW = $clog2(DEPTH);
      logic [W-1:0] mem [DEPTH];
      logic [AW-1:0] wp_q, rp_q;
      logic [AW:0]   cnt_q;
      logic          do_push, do_pop;

      assign push_ready = (cnt_q != (AW+1)'(DEPTH));
      assign pop_valid  = (cnt_q != '0);
      assign pop_data   = mem[rp_q];
      assign do_push    = push_valid && push_ready;
      assign do_pop     = pop_valid && pop_ready;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_push) wp_q <= wp_q + AW'(1);
            if (do_pop)  rp_q <= rp_q + AW'(1);
            case ({do_push, do_pop})
               2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
               2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
               default: cnt_q <= cnt_q;
            endcase
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) mem[wp_q] <= push_data;
      end
   end

endmodule

// File: rtl/wr_rr_arb.sv
module wr_rr_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         take,
   output logic [N-1:0] gnt
);

   localparam int IW = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("wr_rr_arb: N must be at least 2");
   end

   logic [IW-1:0] ptr_q;
   logic [IW-1:0] win;
   logic          found;

   always_comb begin
      found = 1'b0;
      win   = ptr_q;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = (int'(ptr_q) + k) % N;
         if (!found && req[idx]) begin
            found = 1'b1;
            win   = IW'(idx);
         end
      end
      gnt = found ? (N'(1) << win) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (take && found) begin
         ptr_q <= (int'(win) == N - 1) ? '0 : win + IW'(1);
      end
   end

endmodule

// File: rtl/wr_fwd_table.sv
module wr_fwd_table #(
   parameter int NP     = 4,
   parameter int DEST_W = 4,
   parameter int PW     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [DEST_W-1:0]    wdest,
   input  logic [PW-1:0]        wport,
   input  logic [NP*DEST_W-1:0] rd_dest,
   output logic [NP*PW-1:0]     rd_port
);

   localparam int ENTRIES = 1 << DEST_W;

   logic [PW-1:0] ent_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) ent_q[e] <= PW'(e % NP);
      end else if (we) begin
         ent_q[wdest] <= wport;
      end
   end

   for (genvar i = 0; i < NP; i++) begin : g_rd
      assign rd_port[i*PW +: PW] = ent_q[rd_dest[i*DEST_W +: DEST_W]];
   end

endmodule

// File: rtl/wr_router.sv
module wr_router import wr_pkg::*; #(
   parameter int NP        = 4,
   parameter int FLIT_W    = 32,
   parameter int DEST_W    = 4,
   parameter int IN_DEPTH  = 4,
   parameter int OUT_DEPTH = 4,
   localparam int PW       = $clog2(NP)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NP-1:0]        in_valid,
   output logic [NP-1:0]        in_ready,
   input  logic [NP*FLIT_W-1:0] in_flit,
   output logic [NP-1:0]        out_valid,
   input  logic [NP-1:0]        out_ready,
   output logic [NP*FLIT_W-1:0] out_flit,
   input  logic                 tbl_we,
   input  logic [DEST_W-1:0]    tbl_dest,
   input  logic [PW-1:0]        tbl_port
);

   if (NP < 2 || (NP & (NP - 1)) != 0) begin : g_bad_np
      $error("wr_router: NP must be a power of two of at least 2");
   end
   if (FLIT_W < DEST_W + 2) begin : g_bad_flit
      $error("wr_router: FLIT_W too narrow for kind and destination");
   end

   // Flattened cross-stage signals
   logic [NP*FLIT_W-1:0] ib_flat;
   logic [NP-1:0]        ib_valid, ib_pop;
   logic [NP*DEST_W-1:0] rc_dest;
   logic [NP*PW-1:0]     rc_port;
   logic [NP-1:0]        routed;
   logic [NP*PW-1:0]     route_flat;
   logic [NP-1:0]        xfer;
   logic [NP*NP-1:0]     gnt_flat;     // slice o holds the grants of output o
   logic [NP-1:0]        lock_vec;
   logic [NP*PW-1:0]     src_flat;
   logic [NP-1:0]        st_acc;
   logic [NP-1:0]        ld_last_vec;

   wr_fwd_table #(.NP(NP), .DEST_W(DEST_W), .PW(PW)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (tbl_we),
      .wdest   (tbl_dest),
      .wport   (tbl_port),
      .rd_dest (rc_dest),
      .rd_port (rc_port)
   );

   // Input side: buffer, route lookup, request
   for (genvar i = 0; i < NP; i++) begin : g_in
      in_state_e     state_q;
      logic [PW-1:0] route_q;
      logic [1:0]    kind;
      logic          granted;
      logic          drop;

      wr_fifo #(.W(FLIT_W), .DEPTH(IN_DEPTH)) u_ib (
         .clk        (clk),
         .rst_n      (rst_n),
         .push_valid (in_valid[i]),
         .push_ready (in_ready[i]),
         .push_data  (in_flit[i*FLIT_W +: FLIT_W]),
         .pop_valid  (ib_valid[i]),
         .pop_ready  (ib_pop[i]),
         .pop_data   (ib_flat[i*FLIT_W +: FLIT_W])
      );

      assign kind = ib_flat[i*FLIT_W + FLIT_W - 1 -: 2];
      assign rc_dest[i*DEST_W +: DEST_W] = ib_flat[i*FLIT_W +: DEST_W];

      always_comb begin
         granted = 1'b0;
         for (int o = 0; o < NP; o++) granted = granted | gnt_flat[o*NP + i];
      end

      assign xfer[i] = (state_q == IN_GRANTED) && ib_valid[i] && st_acc[route_q];
      assign drop    = (state_q == IN_IDLE) && ib_valid[i] && !kind_opens(kind);
      assign ib_pop[i] = xfer[i] | drop;
      assign routed[i] = (state_q == IN_ROUTED);
      assign route_flat[i*PW +: PW] = route_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            state_q <= IN_IDLE;
            route_q <= '0;
         end else begin
            case (state_q)
               IN_IDLE: begin
                  if (ib_valid[i] && kind_opens(kind)) begin
                     route_q <= rc_port[i*PW +: PW];
                     state_q <= IN_ROUTED;
                  end
               end
               IN_ROUTED: begin
                  if (granted) state_q <= IN_GRANTED;
               end
               IN_GRANTED: begin
                  if (xfer[i] && kind_closes(kind)) state_q <= IN_IDLE;
               end
               default: state_q <= IN_IDLE;
            endcase
         end
      end
   end

   // Output side: arbitration, lock, traversal register, output buffer
   for (genvar o = 0; o < NP; o++) begin : g_out
      logic [NP-1:0]     req;
      logic [NP-1:0]     g;
      logic [PW-1:0]     g_idx;
      logic              locked_q;
      logic [PW-1:0]     src_q;
      logic [FLIT_W-1:0] sel;
      logic              ld;
      logic              st_v_q;
      logic [FLIT_W-1:0] st_d_q;
      logic              ob_ready;

      always_comb begin
         for (int i = 0; i < NP; i++) begin
            req[i] = routed[i] && (route_flat[i*PW +: PW] == PW'(o));
         end
      end

      wr_rr_arb #(.N(NP)) u_arb (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (req & {NP{!locked_q}}),
         .take  (!locked_q),
         .gnt   (g)
      );

      always_comb begin
         g_idx = '0;
         for (int i = 0; i < NP; i++) begin
            if (g[i]) g_idx = PW'(i);
         end
      end

      assign gnt_flat[o*NP +: NP] = g;
      assign sel    = ib_flat[int'(src_q)*FLIT_W +: FLIT_W];
      assign ld     = locked_q && xfer[src_q];
      assign st_acc[o] = !st_v_q || ob_ready;
      assign lock_vec[o] = locked_q;
      assign src_flat[o*PW +: PW] = src_q;
      assign ld_last_vec[o] = ld && kind_closes(sel[FLIT_W-1 -: 2]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            locked_q <= 1'b0;
            src_q    <= '0;
            st_v_q   <= 1'b0;
            st_d_q   <= '0;
         end else begin
            if (!locked_q && (g != '0)) begin
               locked_q <= 1'b1;
               src_q    <= g_idx;
            end else if (ld_last_vec[o]) begin
               locked_q <= 1'b0;
            end
            if (ld) begin
               st_v_q <= 1'b1;
               st_d_q <= sel;
            end else if (ob_ready) begin
               st_v_q <= 1'b0;
            end
         end
      end

      wr_fifo #(.W(FLIT_W), .DEPTH(OUT_DEPTH)) u_ob (
         .clk        (clk),
         .rst_n      (rst_n),
         .push_valid (st_v_q),
         .push_ready (ob_ready),
         .push_data  (st_d_q),
         .pop_valid  (out_valid[o]),
         .pop_ready  (out_ready[o]),
         .pop_data   (out_flit[o*FLIT_W +: FLIT_W])
      );
   end

endmodule

// File: rtl/wr_router_chk.sv
module wr_router_chk #(
   parameter int NP     = 4,
   parameter int FLIT_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NP-1:0]        out_valid,
   input logic [NP-1:0]        out_ready,
   input logic [NP*FLIT_W-1:0] out_flit,
   input logic [NP-1:0]        lock_vec,
   input logic [NP*$clog2(NP)-1:0] src_flat,
   input logic [NP*NP-1:0]     gnt_flat,
   input logic [NP-1:0]        ld_last_vec
);

   localparam int PW = $clog2(NP);

   for (genvar o = 0; o < NP; o++) begin : g_o
      // R7
      out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_flit[o*FLIT_W +: FLIT_W]));

      // R5
      one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(gnt_flat[o*NP +: NP]));

      // R3
      tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(lock_vec[o]) |-> $past(ld_last_vec[o]));

      // R3
      owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lock_vec[o] |=> !lock_vec[o] || $stable(src_flat[o*PW +: PW]));
   end

   for (genvar i = 0; i < NP; i++) begin : g_i
      logic [NP-1:0] hits;
      always_comb begin
         for (int o = 0; o < NP; o++) begin
            hits[o] = lock_vec[o] && (src_flat[o*PW +: PW] == PW'(i));
         end
      end

      // R3
      one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(hits) <= 1);
   end

endmodule

bind wr_router wr_router_chk #(.NP(NP), .FLIT_W(FLIT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_flit    (out_flit),
   .lock_vec    (lock_vec),
   .src_flat    (src_flat),
   .gnt_flat    (gnt_flat),
   .ld_last_vec (ld_last_vec)
);

// File: tb/wr_router_bench.sv
module wr_router_bench;

   localparam int CLK_NS = 10;
   localparam int NP = 4;
   localparam int FW = 32;
   localparam int DW = 4;
   localparam int PW = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NP-1:0]      in_valid = '0;
   logic [NP-1:0]      in_ready;
   logic [NP*FW-1:0]   in_flit = '0;
   logic [NP-1:0]      out_valid;
   logic [NP-1:0]      out_ready = '1;
   logic [NP*FW-1:0]   out_flit;
   logic               tbl_we = 1'b0;
   logic [DW-1:0]      tbl_dest = '0;
   logic [PW-1:0]      tbl_port = '0;

   always #(CLK_NS/2) clk = ~clk;

   wr_router #(.NP(NP), .FLIT_W(FW), .DEST_W(DW), .IN_DEPTH(4), .OUT_DEPTH(4)) u_wr_router (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready), .in_flit (in_flit),
      .out_valid (out_valid), .out_ready (out_ready), .out_flit (out_flit),
      .tbl_we (tbl_we), .tbl_dest (tbl_dest), .tbl_port (tbl_port)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   bit rand_rdy = 1'b0;

   // Reference model state
   logic [FW-1:0] exp_q [NP*NP][$];
   logic [PW-1:0] tbl_m [1<<DW];
   bit            busy_m [NP];
   int            dst_m [NP];
   bit            olock_m [NP];
   int            osrc_m [NP];
   int            head_log [NP][$];
   int            out_cnt [NP];
   bit            hold_m [NP];
   logic [FW-1:0] hold_f [NP];

   task automatic check(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   function automatic int pending();
      int s = 0;
      for (int q = 0; q < NP*NP; q++) s += exp_q[q].size();
      return s;
   endfunction

   initial begin
      for (int e = 0; e < (1<<DW); e++) tbl_m[e] = PW'(e % NP);
      for (int i = 0; i < NP; i++) begin
         busy_m[i] = 0; dst_m[i] = 0; olock_m[i] = 0; osrc_m[i] = 0;
         out_cnt[i] = 0; hold_m[i] = 0; hold_f[i] = '0;
      end
   end

   // Monitor and reference model, sampled on falling edges
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < NP; i++) begin
            if (in_valid[i] && in_ready[i]) begin
               logic [FW-1:0] f;
               f = in_flit[i*FW +: FW];
               if (!busy_m[i]) begin
                  if (f[FW-2]) begin
                     int o;
                     o = int'(tbl_m[f[DW-1:0]]);
                     exp_q[i*NP+o].push_back(f);
                     if (!f[FW-1]) begin busy_m[i] = 1; dst_m[i] = o; end
                  end
               end else begin
                  exp_q[i*NP+dst_m[i]].push_back(f);
                  if (f[FW-1]) busy_m[i] = 0;
               end
            end
         end
         for (int o = 0; o < NP; o++) begin
            logic [FW-1:0] f;
            f = out_flit[o*FW +: FW];
            if (hold_m[o]) check("R7", out_valid[o] && f == hold_f[o], f, hold_f[o]);
            hold_m[o] = out_valid[o] && !out_ready[o];
            hold_f[o] = f;
            if (out_valid[o] && out_ready[o]) begin
               out_cnt[o]++;
               if (!olock_m[o]) begin
                  int hit = -1;
                  for (int i = 0; i < NP; i++) begin
                     if (exp_q[i*NP+o].size() > 0 && exp_q[i*NP+o][0] == f) hit = i;
                  end
                  check("R2,R3 opening flit", hit >= 0 && f[FW-2], f, 0);
                  if (hit >= 0) begin
                     void'(exp_q[hit*NP+o].pop_front());
                     head_log[o].push_back(hit);
                     if (!f[FW-1]) begin olock_m[o] = 1; osrc_m[o] = hit; end
                  end
               end else begin
                  int q;
                  logic [FW-1:0] e;
                  q = osrc_m[o]*NP + o;
                  e = (exp_q[q].size() > 0) ? exp_q[q][0] : '0;
                  check("R3 packet continuation", exp_q[q].size() > 0 && f == e, f, e);
                  if (exp_q[q].size() > 0) void'(exp_q[q].pop_front());
                  if (f[FW-1]) olock_m[o] = 0;
               end
            end
         end
      end
   end

   always @(posedge clk) begin
      if (rand_rdy) begin
         #1;
         out_ready = NP'($urandom);
      end
   end

   task automatic drive(input int i, input logic [FW-1:0] f);
      in_valid[i] = 1'b1;
      in_flit[i*FW +: FW] = f;
      do @(negedge clk); while (!in_ready[i]);
      @(posedge clk); #1;
      in_valid[i] = 1'b0;
   endtask

   task automatic send_pkt(input int i, input int dest, input int len, input int seq);
      for (int k = 0; k < len; k++) begin
         logic [1:0] ty;
         ty = (len == 1) ? 2'b11 : (k == 0) ? 2'b01 : (k == len - 1) ? 2'b10 : 2'b00;
         drive(i, {ty, 2'(i), 20'(seq), 4'(k), 4'(dest)});
      end
   endtask

   task automatic rand_stream(input int i);
      for (int p = 0; p < 6; p++) begin
         send_pkt(i, int'($urandom_range(0, 15)), int'($urandom_range(1, 4)), 100 + p);
      end
   endtask

   task automatic write_tbl(input int d, input int p);
      @(posedge clk); #1;
      tbl_we = 1'b1; tbl_dest = DW'(d); tbl_port = PW'(p);
      @(posedge clk);
      tbl_m[d] = PW'(p);
      #1 tbl_we = 1'b0;
   endtask

   task automatic drain(input string req);
      int n = 0;
      while ((pending() != 0 || out_valid != '0) && n < 3000) begin
         @(posedge clk); n++;
      end
      repeat (8) @(posedge clk);
      #1;
      check(req, pending() == 0, 64'(pending()), 0);
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      finish_run();
   end

   initial begin
      int n;
      int base;
      int tot;
      bit distinct;

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state while reset is held
      check("R1 out_valid in reset", out_valid == '0, 64'(out_valid), 0);
      check("R1 in_ready in reset", in_ready == '1, 64'(in_ready), 64'hF);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid after reset", out_valid == '0, 64'(out_valid), 0);
      check("R1 in_ready after reset", in_ready == '1, 64'(in_ready), 64'hF);

      // R6: pipeline depth of a lone packet (reset table: dest 2 -> port 2)
      @(posedge clk); #1;
      in_valid[0] = 1'b1;
      in_flit[0 +: FW] = {2'b11, 2'd0, 20'd1, 4'd0, 4'd2};
      @(negedge clk);
      check("R6 accepted", in_ready[0], 64'(in_ready[0]), 1);
      @(posedge clk); #1 in_valid[0] = 1'b0;
      n = 0;
      do begin @(negedge clk); n++; end while (!out_valid[2] && n < 20);
      check("R6 latency", n == 5, 64'(n), 5);
      drain("R6 drained");

      // R9, R2: rewritten entry steers the packet (dest 5 resets to port 1)
      write_tbl(5, 3);
      base = out_cnt[3];
      send_pkt(1, 5, 3, 2);
      drain("R2 drained");
      check("R9 rewritten entry used", out_cnt[3] - base == 3, 64'(out_cnt[3] - base), 3);

      // R4: stray continuation flit on an idle input is discarded
      tot = out_cnt[0] + out_cnt[1] + out_cnt[2] + out_cnt[3];
      @(posedge clk); #1;
      drive(2, {2'b00, 2'd2, 20'd3, 4'd0, 4'd0});
      send_pkt(2, 0, 1, 4);
      drain("R4 drained");
      check("R4 stray flit dropped",
            out_cnt[0] + out_cnt[1] + out_cnt[2] + out_cnt[3] - tot == 1,
            64'(out_cnt[0] + out_cnt[1] + out_cnt[2] + out_cnt[3] - tot), 1);

      // R5, R3: all inputs contend for output 2 (dest 6 -> port 2)
      base = head_log[2].size();
      @(posedge clk); #1;
      fork
         begin send_pkt(0, 6, 3, 10); send_pkt(0, 6, 3, 11); end
         begin send_pkt(1, 6, 3, 10); send_pkt(1, 6, 3, 11); end
         begin send_pkt(2, 6, 3, 10); send_pkt(2, 6, 3, 11); end
         begin send_pkt(3, 6, 3, 10); send_pkt(3, 6, 3, 11); end
      join
      drain("R3 contention drained");
      check("R5 packet count", head_log[2].size() - base == 8, 64'(head_log[2].size() - base), 8);
      distinct = 1;
      if (head_log[2].size() - base >= 4) begin
         for (int a = 0; a < 4; a++)
            for (int b = a + 1; b < 4; b++)
               if (head_log[2][base+a] == head_log[2][base+b]) distinct = 0;
      end else distinct = 0;
      check("R5 round-robin first round", distinct, 64'(distinct), 1);

      // R8: stalled output fills the path and stops the input
      @(posedge clk); #1 out_ready[1] = 1'b0;
      fork
         send_pkt(3, 1, 12, 20);
         begin
            repeat (30) @(posedge clk);
            #1;
            check("R8 in_ready low when full", !in_ready[3], 64'(in_ready[3]), 0);
            out_ready[1] = 1'b1;
         end
      join
      drain("R8 no flit lost");

      // Random traffic with random downstream stalls
      rand_rdy = 1'b1;
      fork
         rand_stream(0);
         rand_stream(1);
         rand_stream(2);
         rand_stream(3);
      join
      drain("R3 random traffic drained");
      rand_rdy = 1'b0;
      @(posedge clk); #1 out_ready = '1;
      repeat (4) @(posedge clk);

      finish_run();
   end

endmodule